// File: doc/BRIEF.md
# Isochronous Clock Source Router

This block chooses the bit-clock enables that a serial port's transmitter and receiver run on. It also decides what is carried on two outgoing timing lines that a DTE-side port can present to its peer: one for transmitter timing and one for receiver timing. There are four candidate sources, each a single-cycle enable in the system clock domain:

- the receive baud tick;
- the transmit baud tick;
- the DCE transmit timing clock;
- the DCE receive timing clock.

The two DCE clocks arrive as raw levels. They are synchronized and edge-detected before they can be selected.

A 16-bit clock-mode word sets all four choices at once, through four independent 3-bit selector fields. Isochronous input flow control is a separate gate. When it is enabled, the receiver asks for a pause, and the receive clock comes from an external DCE source, both outgoing timing lines stop producing pulses. The far device clocks its data from those lines, so it stops sending. Plain asynchronous operation is the all-zero mode word: both bit clocks come from the baud ticks and neither timing line is driven.

Top module: `iso_clk_router`

## Requirements
- R1: Transmit selector `mode_word[2:0]`: code 1 passes DCE transmit timing rising edges, code 2 passes DCE receive timing rising edges, and code 0 or any reserved code (3 to 7) passes the transmit baud tick, on `tx_clk_en`.
- R2: Receive selector `mode_word[5:3]`: code 1 selects DCE transmit timing edges, code 2 selects DCE receive timing edges, and 0 or 3 to 7 selects the receive baud tick, on `rx_clk_en`.
- R3: Outgoing transmitter timing selector `mode_word[8:6]`: 1 selects the receive baud tick, 2 the transmit baud tick, 3 DCE transmit timing edges and 4 DCE receive timing edges, all on `tset_clk` with `tset_oe` high. Codes 0 and 5 to 7 leave the line undriven.
- R4: Outgoing receiver timing selector `mode_word[11:9]` uses the same five codes as R3, on `rset_clk` / `rset_oe`.
- R5: An undriven outgoing line holds its clock low and its output enable low.
- R6: A baud tick high in the cycle before clock edge e appears on a selected output after edge e. A DCE clock level that rises and is first sampled at edge e yields exactly one pulse after edge e+2, however long the level stays high.
- R7: When `iso_fc_en` and `rx_pause` are both high and the receive selector is 1 or 2, both outgoing timing lines carry no pulses in that cycle, and their output enables stay as programmed.
- R8: The pause request has no effect when `iso_fc_en` is low or when the receive selector is 0 or reserved.
- R9: Once the pause clears, the next source event is passed whole, starting in the first cycle with the pause low. No partial pulse is produced.
- R10: While reset is active, all outputs are low.
- R11: The four selectors act independently, and `mode_word[15:12]` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_word | input | 16 | Clock-mode word holding the four selectors |
| iso_fc_en | input | 1 | Isochronous input flow control enable |
| rx_pause | input | 1 | Receiver requests that input pause |
| rbrg_tick | input | 1 | Receive baud tick, one cycle wide |
| tbrg_tick | input | 1 | Transmit baud tick, one cycle wide |
| dce_txc | input | 1 | Raw DCE transmit timing clock |
| dce_rxc | input | 1 | Raw DCE receive timing clock |
| tx_clk_en | output | 1 | Selected transmit bit-clock enable |
| rx_clk_en | output | 1 | Selected receive bit-clock enable |
| tset_clk | output | 1 | Outgoing transmitter timing line |
| tset_oe | output | 1 | Output enable of the transmitter timing line |
| rset_clk | output | 1 | Outgoing receiver timing line |
| rset_oe | output | 1 | Output enable of the receiver timing line |

## Verification
Each output is registered once, so the following timing applies:
- The mode word, pause request and baud ticks sampled at a clock edge show at the outputs just after that edge.
- A DCE clock rise passes two synchronizer stages and an edge register, so its pulse appears two edges after the one that first samples it.

The bench's reference model keeps a three-deep history of each DCE level and computes the expected outputs at every rising edge. It compares them at the following falling edge, so every result is checked in exactly the cycle it is due.

// File: rtl/iso_clk_pkg.sv
package iso_clk_pkg;

  localparam int SEL_W    = 3;
  localparam int MODE_W   = 16;
  localparam int TXSEL_LSB = 0;
  localparam int RXSEL_LSB = 3;
  localparam int OUT_LSB0  = 6;
  localparam int N_OUT     = 2;
  localparam int N_DCE     = 2;

  typedef enum logic [SEL_W-1:0] {
    INSEL_BRG    = 3'd0,
    INSEL_DCE_TX = 3'd1,
    INSEL_DCE_RX = 3'd2
  } insel_e;

  typedef enum logic [SEL_W-1:0] {
    OUTSEL_OFF    = 3'd0,
    OUTSEL_RBRG   = 3'd1,
    OUTSEL_TBRG   = 3'd2,
    OUTSEL_DCE_TX = 3'd3,
    OUTSEL_DCE_RX = 3'd4
  } outsel_e;

  typedef struct packed {
    logic rbrg;
    logic tbrg;
    logic dtx;
    logic drx;
  } src_t;

  function automatic logic insel_external(input logic [SEL_W-1:0] code);
    return (code == INSEL_DCE_TX) || (code == INSEL_DCE_RX);
  endfunction

endpackage

// File: rtl/iso_edge_sync.sv
module iso_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], lvl_i};
    prev_d = sync_q[LAST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sync_q[LAST] & ~prev_q;

  // one pulse per rising level, never two back to back
  p_single_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/iso_in_sel.sv
module iso_in_sel
  import iso_clk_pkg::*;
#(
  parameter bit IS_TX = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] code_i,
  input  src_t             src_i,
  output logic             en_o
);
  logic brg;
  logic en_d;

  assign brg = IS_TX ? src_i.tbrg : src_i.rbrg;

  always_comb begin
    unique case (code_i)
      INSEL_DCE_TX: en_d = src_i.dtx;
      INSEL_DCE_RX: en_d = src_i.drx;
      default:      en_d = brg;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_o <= 1'b0;
    else        en_o <= en_d;
  end

  generate
    if (IS_TX) begin : g_chk_tx
      p_brg_path_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == 3'd0 && src_i.tbrg) |=> en_o);
    end else begin : g_chk_rx
      p_brg_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == 3'd0 && src_i.rbrg) |=> en_o);
    end
  endgenerate

endmodule

// File: rtl/iso_out_drv.sv
module iso_out_drv
  import iso_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] code_i,
  input  src_t             src_i,
  input  logic             stop_i,
  output logic             clk_o,
  output logic             oe_o
);
  logic pick;
  logic drive;
  logic clk_d;

  always_comb begin
    drive = 1'b1;
    unique case (code_i)
      OUTSEL_RBRG:   pick = src_i.rbrg;
      OUTSEL_TBRG:   pick = src_i.tbrg;
      OUTSEL_DCE_TX: pick = src_i.dtx;
      OUTSEL_DCE_RX: pick = src_i.drx;
      default: begin
        pick  = 1'b0;
        drive = 1'b0;
      end
    endcase
    clk_d = drive & pick & ~stop_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_o <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      clk_o <= clk_d;
      oe_o  <= drive;
    end
  end

  p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |-> !clk_o);

  p_stop_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !clk_o);

endmodule

// File: rtl/iso_clk_router.sv
module iso_clk_router
  import iso_clk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              iso_fc_en,
  input  logic              rx_pause,
  input  logic              rbrg_tick,
  input  logic              tbrg_tick,
  input  logic              dce_txc,
  input  logic              dce_rxc,
  output logic              tx_clk_en,
  output logic              rx_clk_en,
  output logic              tset_clk,
  output logic              tset_oe,
  output logic              rset_clk,
  output logic              rset_oe
);
  logic [1:0]       rst_pipe_q;
  logic             rst_core_n;
  logic [N_DCE-1:0] dce_lvl;
  logic [N_DCE-1:0] dce_rise;
  src_t             src;
  logic             stop;
  logic [N_OUT-1:0] out_clk;
  logic [N_OUT-1:0] out_oe;
  logic [SEL_W-1:0] rx_code;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  assign dce_lvl = {dce_rxc, dce_txc};

  generate
    for (genvar i = 0; i < N_DCE; i++) begin : g_dce
      iso_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_core_n),
        .lvl_i  (dce_lvl[i]),
        .rise_o (dce_rise[i])
      );
    end
  endgenerate

  always_comb begin
    src.rbrg = rbrg_tick;
    src.tbrg = tbrg_tick;
    src.dtx  = dce_rise[0];
    src.drx  = dce_rise[1];
  end

  assign rx_code = mode_word[RXSEL_LSB +: SEL_W];
  assign stop    = iso_fc_en & rx_pause & insel_external(rx_code);

  iso_in_sel #(.IS_TX(1'b1)) u_tx_sel (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .code_i (mode_word[TXSEL_LSB +: SEL_W]),
    .src_i  (src),
    .en_o   (tx_clk_en)
  );

  iso_in_sel #(.IS_TX(1'b0)) u_rx_sel (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .code_i (rx_code),
    .src_i  (src),
    .en_o   (rx_clk_en)
  );

  generate
    for (genvar g = 0; g < N_OUT; g++) begin : g_out
      iso_out_drv u_drv (
        .clk    (clk),
        .rst_n  (rst_core_n),
        .code_i (mode_word[OUT_LSB0 + g*SEL_W +: SEL_W]),
        .src_i  (src),
        .stop_i (stop),
        .clk_o  (out_clk[g]),
        .oe_o   (out_oe[g])
      );
    end
  endgenerate

  assign tset_clk = out_clk[0];
  assign tset_oe  = out_oe[0];
  assign rset_clk = out_clk[1];
  assign rset_oe  = out_oe[1];

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_core_n |=> !(tset_oe | rset_oe) || !rst_core_n || $past(rst_core_n));

endmodule

// File: tb/iso_clk_router_tb.sv
module iso_clk_router_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mode_word = '0;
  logic        iso_fc_en = 1'b0;
  logic        rx_pause = 1'b0;
  logic        rbrg_tick = 1'b0;
  logic        tbrg_tick = 1'b0;
  logic        dce_txc = 1'b0;
  logic        dce_rxc = 1'b0;
  logic        tx_clk_en, rx_clk_en, tset_clk, tset_oe, rset_clk, rset_oe;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    chk_on  = 1'b0;
  bit    done    = 1'b0;
  string cur_req = "R10";

  // DCE level history: h1 = previous edge, h2, h3 older
  bit tx_h1, tx_h2, tx_h3, rx_h1, rx_h2, rx_h3;
  bit [5:0] exp_v;

  always #5 clk = ~clk;

  iso_clk_router dut_i (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .iso_fc_en(iso_fc_en),
    .rx_pause(rx_pause), .rbrg_tick(rbrg_tick), .tbrg_tick(tbrg_tick),
    .dce_txc(dce_txc), .dce_rxc(dce_rxc), .tx_clk_en(tx_clk_en),
    .rx_clk_en(rx_clk_en), .tset_clk(tset_clk), .tset_oe(tset_oe),
    .rset_clk(rset_clk), .rset_oe(rset_oe)
  );

  function automatic bit pick_in(int code, bit brg, bit etx, bit erx);
    if (code == 1) return etx;
    if (code == 2) return erx;
    return brg;
  endfunction

  function automatic bit pick_out(int code, bit rb, bit tb, bit etx, bit erx);
    case (code)
      1: return rb;
      2: return tb;
      3: return etx;
      4: return erx;
      default: return 1'b0;
    endcase
  endfunction

  // reference model, evaluated at every rising edge
  always @(posedge clk) begin
    bit etx, erx, stopped, oe_t, oe_r;
    int ctx, crx, ct, cr;
    etx = tx_h2 & ~tx_h3;
    erx = rx_h2 & ~rx_h3;
    ctx = mode_word[2:0];
    crx = mode_word[5:3];
    ct  = mode_word[8:6];
    cr  = mode_word[11:9];
    stopped = iso_fc_en && rx_pause && (crx == 1 || crx == 2);
    oe_t = (ct >= 1 && ct <= 4);
    oe_r = (cr >= 1 && cr <= 4);
    exp_v[0] = pick_in(ctx, tbrg_tick, etx, erx);
    exp_v[1] = pick_in(crx, rbrg_tick, etx, erx);
    exp_v[2] = pick_out(ct, rbrg_tick, tbrg_tick, etx, erx) && !stopped;
    exp_v[3] = oe_t;
    exp_v[4] = pick_out(cr, rbrg_tick, tbrg_tick, etx, erx) && !stopped;
    exp_v[5] = oe_r;
    tx_h3 = tx_h2; tx_h2 = tx_h1; tx_h1 = dce_txc;
    rx_h3 = rx_h2; rx_h2 = rx_h1; rx_h1 = dce_rxc;
  end

  always @(negedge clk) begin
    bit [5:0] act;
    act = {rset_oe, rset_clk, tset_oe, tset_clk, rx_clk_en, tx_clk_en};
    if (chk_on && !done) begin
      n_tests++;
      if (act !== exp_v) begin
        n_fail++;
        $display("FAIL %s: outputs {rset_oe,rset_clk,tset_oe,tset_clk,rx,tx} actual %b expected %b at %0t",
                 cur_req, act, exp_v, $time);
      end
    end
  end

  task automatic run(input string req, input logic [15:0] mode, input bit fc,
                     input int pause_mode, input int cycles, input int dce_hold);
    cur_req   = req;
    mode_word = mode;
    iso_fc_en = fc;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      rbrg_tick = ($urandom_range(0, 2) == 0);
      tbrg_tick = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, dce_hold) == 0) dce_txc = ~dce_txc;
      if ($urandom_range(0, dce_hold) == 0) dce_rxc = ~dce_rxc;
      case (pause_mode)
        0: rx_pause = 1'b0;
        1: rx_pause = 1'b1;
        default: rx_pause = ($urandom_range(0, 4) < 2);
      endcase
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: outputs quiet in reset, even with sources active
    rbrg_tick = 1'b1; tbrg_tick = 1'b1; mode_word = 16'h0092;
    repeat (3) @(negedge clk);
    n_tests++;
    if ({rset_oe, rset_clk, tset_oe, tset_clk, rx_clk_en, tx_clk_en} !== 6'b0) begin
      n_fail++;
      $display("FAIL R10: actual %b expected 000000",
               {rset_oe, rset_clk, tset_oe, tset_clk, rx_clk_en, tx_clk_en});
    end
    rbrg_tick = 1'b0; tbrg_tick = 1'b0; mode_word = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_on = 1'b1;

    run("R5",  16'h0000, 1'b0, 0, 200, 3);
    run("R1",  16'h0001, 1'b0, 0, 200, 3);
    run("R1",  16'h0002, 1'b0, 0, 200, 3);
    run("R1",  16'h0005, 1'b0, 0, 200, 3);
    run("R2",  16'h0001 << 3, 1'b0, 0, 200, 3);
    run("R2",  16'h0002 << 3, 1'b0, 0, 200, 3);
    run("R2",  16'h0007 << 3, 1'b0, 0, 200, 3);
    for (int c = 1; c <= 6; c++) begin
      run("R3", 16'(c) << 6, 1'b0, 0, 150, 3);
      run("R4", 16'(c) << 9, 1'b0, 0, 150, 3);
    end
    run("R11", 16'hF000 | 16'h0002 | (16'h1 << 3) | (16'h3 << 6) | (16'h2 << 9), 1'b0, 0, 300, 3);
    run("R6",  16'h0001 | (16'h2 << 3) | (16'h3 << 6) | (16'h4 << 9), 1'b0, 0, 400, 12);
    run("R7",  (16'h1 << 3) | (16'h2 << 6) | (16'h1 << 9), 1'b1, 1, 200, 3);
    run("R8",  (16'h0 << 3) | (16'h2 << 6) | (16'h1 << 9), 1'b1, 1, 200, 3);
    run("R8",  (16'h6 << 3) | (16'h3 << 6) | (16'h4 << 9), 1'b1, 1, 200, 3);
    run("R8",  (16'h2 << 3) | (16'h4 << 6) | (16'h2 << 9), 1'b0, 1, 200, 3);
    run("R9",  (16'h2 << 3) | (16'h1 << 6) | (16'h3 << 9), 1'b1, 2, 400, 3);
    run("R9",  (16'h1 << 3) | (16'h2 << 6) | (16'h4 << 9), 1'b1, 2, 400, 2);

    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule